// File: doc/BRIEF.md
# Audio Sample-Rate Tick Generator

This block turns a slow reference enable into sample strobes for three audio channels. The reference enable is expected to pulse at 1.4112 MHz. The first playback channel runs at one of four fixed rates, chosen by a 2-bit rate code. The second playback channel and the capture channel share a 13-bit programmable divider. Each channel receives a one-clock strobe once per sample period. That strobe is passed on only while the channel is enabled and, for the two playback channels, not paused.

There are two phase counters, and both count reference pulses. One of them serves the fixed-rate channel. The other serves both channels that use the programmable divider, so those two channels stay in phase with each other. Software picks a divider value `D` for a wanted rate `R` as `round(1411200 / R) - 2`. Whenever the rate code or the divider value changes, the affected counter restarts from zero.

Top module: `sample_rate_ticker`

## Requirements
- R1: While `rst` is high, all three strobes are low. Both phase counters restart at zero on the edge where reset is applied.
- R2: The fixed-rate period is 256, 128, 64 or 32 reference pulses for `rate_sel` equal to 0, 1, 2 or 3. These give 5512, 11025, 22050 and 44100 samples per second.
- R3: The programmable period is `prog_div + 2` reference pulses, so the sample rate is 1411200 / (`prog_div` + 2).
- R4: The programmable divider works at both ends of its 13-bit range: `prog_div` = 0 gives a period of 2, and `prog_div` = 8191 gives a period of 8193.
- R5: A strobe is high for exactly one clock. It appears on the clock after the edge that counts the reference pulse completing the period, so two strobes are never high on consecutive clocks.
- R6: While a channel's enable input is low, its strobe stays low.
- R7: While `play0_pause` or `play1_pause` is high, the strobe of that playback channel stays low. The capture channel has no pause input.
- R8: The second playback channel and the capture channel share one phase counter. When both are running, their strobes occur on the same clocks.
- R9: A change of `rate_sel` or `prog_div` restarts the affected phase counter at zero. The first strobe after the change comes a full new period later, counted from the change.
- R10: A clock without a reference pulse does not advance either phase counter. With `ref_tick` held low, no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | Reference enable, one clock wide per 1.4112 MHz period |
| rate_sel | input | 2 | Rate code for the fixed-rate channel |
| prog_div | input | 13 | Programmable divider field (period minus two) |
| play0_en | input | 1 | First playback channel enable |
| play0_pause | input | 1 | First playback channel pause |
| play1_en | input | 1 | Second playback channel enable |
| play1_pause | input | 1 | Second playback channel pause |
| cap_en | input | 1 | Capture channel enable |
| play0_strobe | output | 1 | Sample strobe, fixed-rate playback channel |
| play1_strobe | output | 1 | Sample strobe, programmable playback channel |
| cap_strobe | output | 1 | Sample strobe, capture channel |

## Verification
The port behaviour is fully set by the count held in each phase counter and the period it has latched. A wrong count or a stale latched period shows up within one sample period as a strobe on the wrong clock. A behavioural model in the bench predicts every strobe on every clock, so a misplaced strobe is reported on the clock where it appears. The bench also counts strobes over windows that start at a reload and compares each total with the expected period. This catches off-by-one periods and reloads that fail to restart the phase. Gating faults appear as strobes counted in windows where the channel is disabled or paused.

// File: rtl/srt_pkg.sv
package srt_pkg;

    // Default widths shared by the block and its bench
    localparam int DEF_SEL_W     = 2;
    localparam int DEF_DIV_W     = 13;
    localparam int DEF_FIX_LOG2  = 8;   // slowest fixed rate: reference / 2**8
    localparam int NUM_CH        = 3;
    localparam int NUM_SRC       = 2;

    // Channel roles, also the index into the strobe array
    typedef enum logic [1:0] {
        CH_PLAY0 = 2'd0,
        CH_PLAY1 = 2'd1,
        CH_CAP   = 2'd2
    } chan_id_e;

    // Per-channel run controls
    typedef struct packed {
        logic en;
        logic pause;
    } chan_ctl_t;

    // Which phase counter drives a channel: 0 = fixed, 1 = programmable
    function automatic int src_of(input int ch);
        return (ch == int'(CH_PLAY0)) ? 0 : 1;
    endfunction

endpackage

// File: rtl/rate_phase.sv
module rate_phase #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_tick,
    input  logic [W-1:0] period,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] per_q;
    logic         reload;

    assign reload = (period != per_q);
    assign wrap   = !reload && ref_tick && (cnt_q == per_q - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            per_q <= period;
        end else if (reload) begin
            cnt_q <= '0;
            per_q <= period;
        end else if (ref_tick) begin
            cnt_q <= wrap ? '0 : cnt_q + ONE;
        end
    end

    // R3: the phase never reaches the latched period
    a_r3_phase_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q < per_q);

    // R9: a new period restarts the phase at zero
    a_r9_reload_clears: assert property (@(posedge clk) disable iff (rst)
        (period != per_q) |=> (cnt_q == '0));

    // R10: without a reference pulse the phase holds
    a_r10_hold_phase: assert property (@(posedge clk) disable iff (rst)
        (!ref_tick && period == per_q) |=> $stable(cnt_q));

endmodule

// File: rtl/tick_gate.sv
module tick_gate (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  srt_pkg::chan_ctl_t ctl,
    output logic tick
);
    logic tick_q;

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= wrap && ctl.en && !ctl.pause;
    end

    assign tick = tick_q;

    // R5: a strobe lasts one clock
    a_r5_one_clock: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);

    // R6: disabled channel stays quiet
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |=> !tick_q);

    // R7: paused channel stays quiet
    a_r7_paused_quiet: assert property (@(posedge clk) disable iff (rst)
        ctl.pause |=> !tick_q);

endmodule

// File: rtl/sample_rate_ticker.sv
module sample_rate_ticker #(
    parameter int SEL_W    = srt_pkg::DEF_SEL_W,
    parameter int DIV_W    = srt_pkg::DEF_DIV_W,
    parameter int FIX_LOG2 = srt_pkg::DEF_FIX_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic [DIV_W-1:0] prog_div,
    input  logic             play0_en,
    input  logic             play0_pause,
    input  logic             play1_en,
    input  logic             play1_pause,
    input  logic             cap_en,
    output logic             play0_strobe,
    output logic             play1_strobe,
    output logic             cap_strobe
);
    import srt_pkg::*;

    localparam int CNT_W = ((DIV_W + 1) > (FIX_LOG2 + 1)) ? (DIV_W + 1) : (FIX_LOG2 + 1);
    localparam logic [CNT_W-1:0] FIX_MAX  = CNT_W'(1) << FIX_LOG2;
    localparam logic [CNT_W-1:0] PROG_OFS = CNT_W'(2);

    logic [CNT_W-1:0] src_period [NUM_SRC];
    logic [NUM_SRC-1:0] src_wrap;
    chan_ctl_t        ch_ctl  [NUM_CH];
    logic [NUM_CH-1:0] ch_tick;

    // Fixed path: power-of-two division; programmable path: field plus two
    assign src_period[0] = FIX_MAX >> rate_sel;
    assign src_period[1] = CNT_W'(prog_div) + PROG_OFS;

    assign ch_ctl[CH_PLAY0] = '{en: play0_en, pause: play0_pause};
    assign ch_ctl[CH_PLAY1] = '{en: play1_en, pause: play1_pause};
    assign ch_ctl[CH_CAP]   = '{en: cap_en,   pause: 1'b0};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rate_phase #(.W(CNT_W)) u_phase (
            .clk      (clk),
            .rst      (rst),
            .ref_tick (ref_tick),
            .period   (src_period[s]),
            .wrap     (src_wrap[s])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tick_gate u_gate (
            .clk  (clk),
            .rst  (rst),
            .wrap (src_wrap[src_of(c)]),
            .ctl  (ch_ctl[c]),
            .tick (ch_tick[c])
        );
    end

    assign play0_strobe = ch_tick[CH_PLAY0];
    assign play1_strobe = ch_tick[CH_PLAY1];
    assign cap_strobe   = ch_tick[CH_CAP];

    // R1: reset silences every strobe on the next clock
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (ch_tick == '0));

    // R8: shared divider keeps the two channels aligned
    a_r8_shared_phase: assert property (@(posedge clk) disable iff (rst)
        (play1_strobe && $past(cap_en)) |-> cap_strobe);

endmodule

// File: tb/test_sample_rate_ticker.sv
module test_sample_rate_ticker;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic [12:0] prog_div = 13'd0;
    logic        play0_en = 1'b0, play0_pause = 1'b0;
    logic        play1_en = 1'b0, play1_pause = 1'b0;
    logic        cap_en = 1'b0;
    logic        play0_strobe, play1_strobe, cap_strobe;

    int n_checks = 0, n_fail = 0;
    int ref_mode = 0;   // 0 continuous, 1 every third clock, 2 off
    int ref_phase = 0;
    bit done = 0;

    // strobe tallies for the current window
    int c0, c1, c2, split, dbl;
    bit p0, p1, p2;

    // behavioural expectation
    int fc = 0, fpq = 256, pc = 0, ppq = 2;
    bit x0 = 0, x1 = 0, x2 = 0;

    sample_rate_ticker i_sample_rate_ticker (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .rate_sel(rate_sel),
        .prog_div(prog_div), .play0_en(play0_en), .play0_pause(play0_pause),
        .play1_en(play1_en), .play1_pause(play1_pause), .cap_en(cap_en),
        .play0_strobe(play0_strobe), .play1_strobe(play1_strobe),
        .cap_strobe(cap_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model: period per channel from the requirements, phase counted in integers
    always @(posedge clk) begin
        int fper, pper;
        bit fw, pw;
        fper = 256 >> rate_sel;
        pper = int'(prog_div) + 2;
        fw = 0; pw = 0;
        if (rst) begin
            fc = 0; fpq = fper; pc = 0; ppq = pper;
        end else begin
            if (fper != fpq) begin fpq = fper; fc = 0; end
            else if (ref_tick) begin
                if (fc == fpq - 1) begin fc = 0; fw = 1; end else fc++;
            end
            if (pper != ppq) begin ppq = pper; pc = 0; end
            else if (ref_tick) begin
                if (pc == ppq - 1) begin pc = 0; pw = 1; end else pc++;
            end
        end
        x0 = !rst && fw && play0_en && !play0_pause;
        x1 = !rst && pw && play1_en && !play1_pause;
        x2 = !rst && pw && cap_en;
    end

    // Per-clock comparison, then reference drive, away from the rising edge
    always @(negedge clk) begin
        check(play0_strobe === x0, "R5 play0 cycle", int'(play0_strobe), int'(x0));
        check(play1_strobe === x1, "R5 play1 cycle", int'(play1_strobe), int'(x1));
        check(cap_strobe === x2, "R5 cap cycle", int'(cap_strobe), int'(x2));
        ref_phase = (ref_phase == 2) ? 0 : ref_phase + 1;
        ref_tick = (ref_mode == 0) || (ref_mode == 1 && ref_phase == 0);
    end

    task automatic clear_counts();
        c0 = 0; c1 = 0; c2 = 0; split = 0;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
            if (play0_strobe && p0) dbl++;
            if (play1_strobe && p1) dbl++;
            if (cap_strobe && p2) dbl++;
            p0 = play0_strobe; p1 = play1_strobe; p2 = cap_strobe;
            c0 += int'(play0_strobe);
            c1 += int'(play1_strobe);
            c2 += int'(cap_strobe);
            if (play1_strobe != cap_strobe) split++;
        end
    endtask

    initial begin
        dbl = 0; p0 = 0; p1 = 0; p2 = 0;
        clear_counts();
        run(4);
        check(!play0_strobe && !play1_strobe && !cap_strobe, "R1 reset quiet",
              int'(play0_strobe) + int'(play1_strobe) + int'(cap_strobe), 0);
        rst = 1'b0;
        play0_en = 1'b1;

        // R2: each fixed rate code, starting at a reload
        for (int s = 3; s >= 0; s--) begin
            int per;
            per = 256 >> s;
            rate_sel = 2'(s);
            clear_counts();
            run(4 * per + 1);
            check(c0 == 4, "R2 fixed rate window", c0, 4);
        end

        // R3: programmable period = field + 2
        play1_en = 1'b1; cap_en = 1'b1;
        prog_div = 13'd5;
        clear_counts();
        run(22);
        check(c1 == 3, "R3 programmable play1", c1, 3);
        check(c2 == 3, "R3 programmable capture", c2, 3);

        // R4: divider range ends
        prog_div = 13'd0;
        clear_counts();
        run(21);
        check(c1 == 10, "R4 divider zero", c1, 10);
        prog_div = 13'd8191;
        clear_counts();
        run(8193);
        check(c1 == 0, "R4 divider max early", c1, 0);
        run(1);
        check(c1 == 1, "R4 divider max", c1, 1);

        // R6: disabled channel silent, the other runs
        prog_div = 13'd3;
        play1_en = 1'b0;
        clear_counts();
        run(26);
        check(c1 == 0, "R6 disabled play1", c1, 0);
        check(c2 == 5, "R6 capture still runs", c2, 5);

        // R7: pause on both playback channels, capture unaffected
        play1_en = 1'b1; play1_pause = 1'b1; play0_pause = 1'b1;
        rate_sel = 2'd3;
        clear_counts();
        run(65);
        check(c1 == 0, "R7 paused play1", c1, 0);
        check(c0 == 0, "R7 paused play0", c0, 0);
        check(c2 == 13, "R7 capture has no pause", c2, 13);
        play0_pause = 1'b0;
        clear_counts();
        run(64);
        check(c0 == 2, "R7 play0 resumes", c0, 2);

        // R8: shared divider alignment
        play1_pause = 1'b0;
        clear_counts();
        run(50);
        check(split == 0, "R8 shared phase split", split, 0);
        check(c1 == 10 && c2 == 10, "R8 shared counts", c1 + c2, 20);

        // R9: mid-period change restarts the phase
        prog_div = 13'd10;
        run(5);
        prog_div = 13'd4;
        clear_counts();
        run(6);
        check(c1 == 0, "R9 no early strobe", c1, 0);
        run(1);
        check(c1 == 1, "R9 first strobe after reload", c1, 1);

        // R10: reference held low, then sparse reference
        ref_mode = 2;
        clear_counts();
        run(300);
        check(c0 + c1 + c2 == 0, "R10 no reference no strobe", c0 + c1 + c2, 0);
        ref_mode = 1;
        clear_counts();
        run(600);
        check(c1 >= 33 && c1 <= 34, "R10 sparse reference rate", c1, 33);

        check(dbl == 0, "R5 no back-to-back strobes", dbl, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule